// File: doc/BRIEF.md
# MICROWIRE Slave Shift Port

This block is the slave side of a MICROWIRE serial link. An external master supplies the shift clock on `ckin_i`. The host loads the outgoing word through two byte registers and arms the port by writing the high byte. The port then drives the MSB onto `so_o` straight away. It shifts 8 or 16 bits out on `so_o` while it takes in the same number of bits from `si_i`, and it raises `done_o` once the count is reached.

While `done_o` is high the port is idle. In that state `so_o` is not driven, and every edge on `ckin_i` is ignored. Clock pulses that arrive after a transfer has finished have no effect until the host arms the port again.

The clock input and the data input pass through the same synchronizer, so they stay aligned. Edges are detected in the system clock domain. The received word is copied to the readable registers in the cycle in which `done_o` rises. The chip-select pins do not take part in the transfer. In this mode they are plain general-purpose I/O, controlled by a data register and a direction register.

Top module: `mw_slave_port`

## Requirements
- R1: After reset, `done_o`=1, `so_oe_o`=0, `cs_oe_o`=0, and the read values at address 0 (received high), address 1 (received low) and address 3 (direction) are all 0.
- R2: While `done_o`=1 and no arming write occurs, edges on `ckin_i` change neither `done_o`, nor `so_oe_o`, nor the read values at addresses 0 and 1.
- R3: A write to address 0 while `slave_mode_i`=1 makes `done_o`=0 and `so_oe_o`=1 in the next cycle, with `so_o` equal to bit 7 of the written byte.
- R4: While `slave_mode_i`=0, a write to address 0 does not arm the port. Dropping `slave_mode_i` during a transfer forces `done_o`=1 on the next clock edge and leaves the read values unchanged.
- R5: `ckin_i` and `si_i` pass through two synchronizer stages plus one edge register. A level change that is present at system clock edge n takes effect at edge n+2.
- R6: `wide_i` and `pol_i` are captured when the port is armed. With `pol_i`=0, SI is sampled on a rising CKIN edge and SO advances on a falling edge. With `pol_i`=1 the two edges swap roles.
- R7: With `wide_i`=0, after 8 sample edges `done_o`=1 and `so_oe_o`=0. The byte sent is the address-0 byte, MSB first. The byte received, MSB first, is read at address 0, and address 1 is left unchanged.
- R8: With `wide_i`=1 the 16-bit word sent is {address-0 byte, address-1 byte}, MSB first. A write to address 1 does not arm the port. After 16 sample edges the received high byte is read at address 0 and the received low byte at address 1.
- R9: The read values at addresses 0 and 1 change only in the cycle in which `done_o` rises, and they keep their old contents during a transfer.
- R10: Once a transfer has completed, further CKIN edges are ignored until the next write to address 0.
- R11: SO advances only after a sample edge. A shift edge that comes before the first sample edge leaves `so_o` at the MSB.
- R12: A write to address 2 sets `cs_o`. A write to address 3 sets `cs_oe_o` (1 = output). A read at address 2 returns `cs_i`, and a read at address 3 returns the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slave_mode_i | input | 1 | 1 selects slave operation |
| wide_i | input | 1 | Transfer length: 0 = 8 bits, 1 = 16 bits |
| pol_i | input | 1 | Clock polarity: 0 samples on a rising CKIN edge, 1 on a falling edge |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 2 | Host write address |
| wr_data_i | input | BYTE_W | Host write data |
| rd_addr_i | input | 2 | Host read address |
| rd_data_o | output | BYTE_W | Host read data |
| ckin_i | input | 1 | Shift clock from the external master |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for SO; 0 means tri-state |
| done_o | output | 1 | Transfer complete / idle flag |
| cs_i | input | NUM_CS | Chip-select pin levels |
| cs_o | output | NUM_CS | Chip-select output values |
| cs_oe_o | output | NUM_CS | Chip-select direction, 1 = output |

## Verification
The assertions check several rules on every cycle. Idle state stays frozen until a write arms the port. Arming clears the count. SO never moves without a preceding sample. The readable data changes only together with the rise of the done flag. Leaving slave mode forces the port idle, and a direction write shows up on the pins. Other behaviours only the bench scenarios can show. These are the bit order of both transfer lengths under both polarities, and the exact two-cycle latency from a CKIN change to SO. They also include the effect of a shift edge that arrives before any sample, and the abort in the middle of a transfer. A behavioural model compared on every clock covers the full output state throughout.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [1:0] {
    REG_HI     = 2'd0,
    REG_LO     = 2'd1,
    REG_CS_DAT = 2'd2,
    REG_CS_DIR = 2'd3
  } mw_reg_e;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mw_edge_det.sv
module mw_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/mw_shift_core.sv
module mw_shift_core #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              abort_i,
  input  logic              wide_i,
  input  logic              pol_i,
  input  logic [BYTE_W-1:0] tx_hi_i,
  input  logic [BYTE_W-1:0] tx_lo_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              si_i,
  output logic              done_o,
  output logic              so_o,
  output logic [BYTE_W-1:0] rx_hi_o,
  output logic [BYTE_W-1:0] rx_lo_o
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_WIDE = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(BYTE_W - 1);

  logic              done_q, pend_q, wide_q, pol_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] tx_q, rx_q, rx_nxt;
  logic [BYTE_W-1:0] rx_hi_q, rx_lo_q;
  logic              samp, shft;
  logic [CNT_W-1:0]  last;

  always_comb begin
    samp   = pol_q ? fall_i : rise_i;
    shft   = pol_q ? rise_i : fall_i;
    last   = wide_q ? LAST_WIDE : LAST_BYTE;
    rx_nxt = {rx_q[WORD_W-2:0], si_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b1;
      pend_q  <= 1'b0;
      wide_q  <= 1'b0;
      pol_q   <= 1'b0;
      cnt_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      rx_hi_q <= '0;
      rx_lo_q <= '0;
    end else if (abort_i) begin
      done_q <= 1'b1;
      pend_q <= 1'b0;
    end else if (arm_i) begin
      done_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      rx_q   <= '0;
      wide_q <= wide_i;
      pol_q  <= pol_i;
      tx_q   <= wide_i ? {tx_hi_i, tx_lo_i} : {tx_hi_i, {BYTE_W{1'b0}}};
    end else if (!done_q) begin
      if (samp) begin
        rx_q   <= rx_nxt;
        cnt_q  <= cnt_q + 1'b1;
        pend_q <= 1'b1;
        if (cnt_q == last) begin
          done_q <= 1'b1;
          if (wide_q) begin
            rx_hi_q <= rx_nxt[WORD_W-1:BYTE_W];
            rx_lo_q <= rx_nxt[BYTE_W-1:0];
          end else begin
            rx_hi_q <= rx_nxt[BYTE_W-1:0];
          end
        end
      end else if (shft && pend_q) begin
        tx_q   <= {tx_q[WORD_W-2:0], 1'b0};
        pend_q <= 1'b0;
      end
    end
  end

  assign done_o  = done_q;
  assign so_o    = tx_q[WORD_W-1];
  assign rx_hi_o = rx_hi_q;
  assign rx_lo_o = rx_lo_q;

  assert_idle_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !arm_i) |=> ($stable(rx_hi_q) && $stable(rx_lo_q)));

  assert_arm_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !abort_i) |=> (!done_q && cnt_q == '0));

  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(WORD_W));

  assert_rx_on_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(rx_hi_q) || !$stable(rx_lo_q)) |-> (done_q && !$past(done_q)));

  assert_stay_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !arm_i) |=> done_q);

  assert_no_early_shift_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && !arm_i) |=> $stable(tx_q));
endmodule

// File: rtl/mw_cs_gpio.sv
module mw_cs_gpio #(
  parameter int NUM_CS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_dat_i,
  input  logic              wr_dir_i,
  input  logic [NUM_CS-1:0] wdata_i,
  output logic [NUM_CS-1:0] cs_o,
  output logic [NUM_CS-1:0] cs_oe_o
);
  logic [NUM_CS-1:0] dat_q, dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_q <= '0;
      dir_q <= '0;
    end else begin
      if (wr_dat_i) dat_q <= wdata_i;
      if (wr_dir_i) dir_q <= wdata_i;
    end
  end

  assign cs_o    = dat_q;
  assign cs_oe_o = dir_q;

  assert_dir_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir_i |=> (cs_oe_o == $past(wdata_i)));
endmodule

// File: rtl/mw_slave_port.sv
module mw_slave_port
  import mw_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int NUM_CS      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slave_mode_i,
  input  logic              wide_i,
  input  logic              pol_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              ckin_i,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              done_o,
  input  logic [NUM_CS-1:0] cs_i,
  output logic [NUM_CS-1:0] cs_o,
  output logic [NUM_CS-1:0] cs_oe_o
);
  logic [1:0]        sync_q;
  logic              ck_rise, ck_fall;
  logic              arm, done, so_raw;
  logic [BYTE_W-1:0] tx_lo_q, rx_hi, rx_lo;
  mw_reg_e           wsel, rsel;

  assign wsel = mw_reg_e'(wr_addr_i);
  assign rsel = mw_reg_e'(rd_addr_i);
  assign arm  = wr_en_i && (wsel == REG_HI) && slave_mode_i;

  mw_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({si_i, ckin_i}),
    .q_o    (sync_q)
  );

  mw_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (sync_q[0]),
    .rise_o (ck_rise),
    .fall_o (ck_fall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          tx_lo_q <= '0;
    else if (wr_en_i && wsel == REG_LO)   tx_lo_q <= wr_data_i;
  end

  mw_shift_core #(.BYTE_W(BYTE_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm),
    .abort_i (!slave_mode_i),
    .wide_i  (wide_i),
    .pol_i   (pol_i),
    .tx_hi_i (wr_data_i),
    .tx_lo_i (tx_lo_q),
    .rise_i  (ck_rise),
    .fall_i  (ck_fall),
    .si_i    (sync_q[1]),
    .done_o  (done),
    .so_o    (so_raw),
    .rx_hi_o (rx_hi),
    .rx_lo_o (rx_lo)
  );

  mw_cs_gpio #(.NUM_CS(NUM_CS)) u_gpio (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_dat_i (wr_en_i && wsel == REG_CS_DAT),
    .wr_dir_i (wr_en_i && wsel == REG_CS_DIR),
    .wdata_i  (wr_data_i[NUM_CS-1:0]),
    .cs_o     (cs_o),
    .cs_oe_o  (cs_oe_o)
  );

  assign done_o  = done;
  assign so_oe_o = ~done;
  assign so_o    = done ? 1'b0 : so_raw;

  always_comb begin
    case (rsel)
      REG_HI:     rd_data_o = rx_hi;
      REG_LO:     rd_data_o = rx_lo;
      REG_CS_DAT: rd_data_o = BYTE_W'(cs_i);
      REG_CS_DIR: rd_data_o = BYTE_W'(cs_oe_o);
      default:    rd_data_o = '0;
    endcase
  end

  assert_mode_off_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slave_mode_i |=> done_o);
endmodule

// File: tb/mw_slave_port_tb.sv
module mw_slave_port_tb;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       slave_mode = 1'b1, wide = 1'b0, pol = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic       ckin = 1'b0, si = 1'b0;
  logic       so, so_oe, done;
  logic [7:0] cs_in = '0, cs_out, cs_oe;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  mw_slave_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .slave_mode_i(slave_mode), .wide_i(wide), .pol_i(pol),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .ckin_i(ckin), .si_i(si), .so_o(so), .so_oe_o(so_oe), .done_o(done),
    .cs_i(cs_in), .cs_o(cs_out), .cs_oe_o(cs_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model, updated on each rising clock
  bit        m_done, m_pend, m_wide, m_pol;
  int        m_cnt;
  bit [15:0] m_tx, m_rx;
  bit [7:0]  m_hi, m_lo, m_txlo, m_dat, m_dir;
  bit        ck_h[3];
  bit        si_h[2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_done = 1; m_pend = 0; m_wide = 0; m_pol = 0; m_cnt = 0;
      m_tx = 0; m_rx = 0; m_hi = 0; m_lo = 0; m_txlo = 0; m_dat = 0; m_dir = 0;
      foreach (ck_h[i]) ck_h[i] = 0;
      foreach (si_h[i]) si_h[i] = 0;
    end else begin
      bit rise, fall, s_edge, h_edge, sbit;
      bit [15:0] nx;
      rise = ck_h[1] && !ck_h[2];
      fall = !ck_h[1] && ck_h[2];
      sbit = si_h[1];
      s_edge = m_pol ? fall : rise;
      h_edge = m_pol ? rise : fall;
      if (!slave_mode) begin
        m_done = 1; m_pend = 0;
      end else if (wr_en && wr_addr == 2'd0) begin
        m_done = 0; m_pend = 0; m_cnt = 0; m_rx = 0;
        m_wide = wide; m_pol = pol;
        m_tx = wide ? {wr_data, m_txlo} : {wr_data, 8'h00};
      end else if (!m_done) begin
        if (s_edge) begin
          nx = {m_rx[14:0], sbit};
          m_rx = nx; m_pend = 1; m_cnt++;
          if (m_cnt == (m_wide ? 16 : 8)) begin
            m_done = 1;
            if (m_wide) begin m_hi = nx[15:8]; m_lo = nx[7:0]; end
            else m_hi = nx[7:0];
          end
        end else if (h_edge && m_pend) begin
          m_tx = m_tx << 1; m_pend = 0;
        end
      end
      if (wr_en && wr_addr == 2'd1) m_txlo = wr_data;
      if (wr_en && wr_addr == 2'd2) m_dat = wr_data;
      if (wr_en && wr_addr == 2'd3) m_dir = wr_data;
      ck_h[2] = ck_h[1]; ck_h[1] = ck_h[0]; ck_h[0] = ckin;
      si_h[1] = si_h[0]; si_h[0] = si;
    end
  end

  // per-cycle comparison, clear of both clock edges
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      logic [7:0] exp_rd;
      case (rd_addr)
        2'd0: exp_rd = m_hi;
        2'd1: exp_rd = m_lo;
        2'd2: exp_rd = cs_in;
        default: exp_rd = m_dir;
      endcase
      chk("R7 model done_o", done, m_done);
      chk("R2 model so_oe_o", so_oe, !m_done);
      chk("R6 model so_o", so, m_done ? 1'b0 : m_tx[15]);
      chk("R9 model rd_data_o", rd_data, exp_rd);
      chk("R12 model cs_o", cs_out, m_dat);
      chk("R12 model cs_oe_o", cs_oe, m_dir);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hwr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic xfer(input int nbits, input logic p, input logic [15:0] si_word,
                      output logic [15:0] so_word);
    so_word = '0;
    for (int i = 0; i < nbits; i++) begin
      si = si_word[nbits-1-i];
      step(HOLD);
      so_word = {so_word[14:0], so};
      ckin = p ? 1'b0 : 1'b1;
      step(HOLD);
      ckin = p ? 1'b1 : 1'b0;
      step(HOLD);
    end
  endtask

  task automatic rd_at(input logic [1:0] a, input string tag, input logic [7:0] exp);
    rd_addr = a;
    step(1);
    chk(tag, rd_data, exp);
    rd_addr = 2'd0;
  endtask

  initial begin
    logic [15:0] sw, sw2;
    step(3);
    rst_n = 1'b1;
    step(2);
    // R1 reset state
    chk("R1 done after reset", done, 1);
    chk("R1 so_oe after reset", so_oe, 0);
    chk("R1 cs_oe after reset", cs_oe, 0);
    rd_at(2'd0, "R1 rd hi after reset", 8'h00);
    rd_at(2'd1, "R1 rd lo after reset", 8'h00);
    rd_at(2'd3, "R1 rd dir after reset", 8'h00);

    // R2 clock ignored while idle
    for (int i = 0; i < 8; i++) begin
      si = i[0]; ckin = 1'b1; step(HOLD); ckin = 1'b0; step(HOLD);
    end
    chk("R2 done stays idle", done, 1);
    chk("R2 so_oe stays off", so_oe, 0);
    rd_at(2'd0, "R2 rd hi unchanged", 8'h00);

    // R4 write ignored outside slave mode
    slave_mode = 1'b0;
    hwr(2'd0, 8'h12);
    step(1);
    chk("R4 no arm in master mode", done, 1);
    slave_mode = 1'b1;
    step(2);

    // R3 arm, then R5 latency of a falling edge
    wide = 1'b0; pol = 1'b0;
    hwr(2'd0, 8'h80);
    chk("R3 done cleared", done, 0);
    chk("R3 so_oe on", so_oe, 1);
    chk("R3 MSB on so", so, 1);
    si = 1'b1; step(HOLD);
    ckin = 1'b1; step(HOLD);
    ckin = 1'b0;
    step(1); chk("R5 so held 1 edge", so, 1);
    step(1); chk("R5 so held 2 edges", so, 1);
    step(1); chk("R5 so advanced at edge n+2", so, 0);
    step(HOLD);
    xfer(7, 1'b0, 16'h0033, sw);
    chk("R7 done after 8 bits", done, 1);
    chk("R7 so_oe off after 8 bits", so_oe, 0);
    rd_at(2'd0, "R7 received byte", 8'hB3);

    // R7 / R6 pol 0 byte exchange
    hwr(2'd0, 8'hA5);
    xfer(8, 1'b0, 16'h003C, sw);
    chk("R6 R7 sent byte pol0", sw[7:0], 8'hA5);
    chk("R7 done", done, 1);
    rd_at(2'd0, "R7 rx byte pol0", 8'h3C);
    rd_at(2'd1, "R7 low untouched in 8-bit", 8'h00);

    // R8 / R6 / R9 16-bit, pol 1
    ckin = 1'b1; step(HOLD);
    wide = 1'b1; pol = 1'b1;
    hwr(2'd1, 8'h5A);
    chk("R8 low write does not arm", done, 1);
    hwr(2'd0, 8'hC3);
    wide = 1'b0; pol = 1'b0;   // captured at arm, later changes have no effect
    xfer(8, 1'b1, 16'h009E, sw);
    chk("R8 busy after 8 of 16", done, 0);
    chk("R9 rd hi held mid-transfer", rd_data, 8'h3C);
    xfer(8, 1'b1, 16'h0071, sw2);
    chk("R6 R8 sent word pol1", {sw[7:0], sw2[7:0]}, 16'hC35A);
    chk("R8 done after 16", done, 1);
    rd_at(2'd0, "R8 rx high", 8'h9E);
    rd_at(2'd1, "R8 rx low", 8'h71);

    // R10 late edges ignored
    for (int i = 0; i < 3; i++) begin
      si = 1'b1; ckin = 1'b0; step(HOLD); ckin = 1'b1; step(HOLD);
    end
    chk("R10 done held", done, 1);
    chk("R10 so_oe off", so_oe, 0);
    rd_at(2'd0, "R10 rx high held", 8'h9E);

    // R11 shift edge before first sample (ckin high, pol 0)
    wide = 1'b0; pol = 1'b0;
    hwr(2'd0, 8'h80);
    ckin = 1'b0; step(HOLD + 2);
    chk("R11 so stays MSB", so, 1);
    xfer(8, 1'b0, 16'h0055, sw);
    chk("R11 sent byte", sw[7:0], 8'h80);
    rd_at(2'd0, "R11 rx byte", 8'h55);

    // R4 abort mid-transfer
    hwr(2'd0, 8'hFF);
    xfer(3, 1'b0, 16'h0002, sw);
    slave_mode = 1'b0;
    step(2);
    chk("R4 abort sets done", done, 1);
    chk("R4 abort so_oe off", so_oe, 0);
    rd_at(2'd0, "R4 rx unchanged after abort", 8'h55);
    slave_mode = 1'b1;
    step(2);

    // R12 chip-select GPIO
    hwr(2'd3, 8'hF0);
    hwr(2'd2, 8'hAA);
    chk("R12 cs_oe", cs_oe, 8'hF0);
    chk("R12 cs_o", cs_out, 8'hAA);
    cs_in = 8'h3C;
    rd_at(2'd2, "R12 cs pin read", 8'h3C);
    rd_at(2'd3, "R12 dir read", 8'hF0);
    step(2);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule